// File: doc/BRIEF.md
# Scan Chain with Test Sequencer and Switching Monitor

This block is a chain of L scan cells with a built-in sequencer that applies scan tests and measures how much the chain switches while doing so. In normal operation every cell loads its functional input on each clock. After a start request the sequencer alternates L-cycle shift phases with single capture cycles. Unloading one response shares its shift phase with loading the next vector. After the last unload a done pulse is raised.

While the chain shifts, an optional data-gating mode holds the parallel outputs that feed downstream logic at the value they had before shifting began, so that logic sees no shift activity. Only the serial output carries the moving bits. Four saturating counters report activity over one test run. Two are measured, flip-flop by flip-flop, on every shift edge and every capture edge. The other two are estimates computed with a position-weighted rule, one for the patterns loaded and one for the responses unloaded.

Top module: `scan_activity_chain`

## Requirements
- R1: While the sequencer is idle, the chain loads `func_in` on every clock. With `scan_en` low, `func_out` shows the chain contents one cycle after the edge that loaded them.
- R2: `start` is accepted only while idle, and accepting it clears all four counters. `scan_en` is then high for exactly L consecutive cycles in each shift phase. Consecutive shift phases are separated by one capture cycle with `scan_en` low, in which the chain loads `func_in`.
- R3: On each shift edge, `scan_in` enters cell 0 and every cell k>0 takes the old value of cell k-1. `scan_out` is always the value of cell L-1.
- R4: A run whose `nvec` value is sampled at start holds nvec+1 shift phases and nvec capture cycles. A `start` raised during a run has no effect.
- R5: `done` is high for exactly one cycle, the cycle after the last shift edge of a run.
- R6: When `gate_en` is 1 during a shift phase, `func_out` holds the chain contents from just before that phase. When `gate_en` is 0, `func_out` equals the chain contents at all times.
- R7: `shift_tog` adds, on every shift edge, the number of cells whose value changes.
- R8: `cap_tog` adds, on every capture edge, the Hamming distance between the chain before the edge and `func_in`.
- R9: `in_weight` adds L-k on the k-th cycle (k counted from 0) of any shift phase where k>0 and `scan_in` differs from its value in the previous cycle.
- R10: On the first cycle of each shift phase that follows a capture, `out_weight` adds L-1-j for every j in 0..L-2 where cell j differs from cell j+1.
- R11: Each counter saturates at 2^CW-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (idle only) |
| gate_en | input | 1 | Hold parallel outputs while shifting |
| nvec | input | VW | Number of capture cycles in the run |
| func_in | input | L | Functional data into the cells |
| scan_in | input | 1 | Serial input to cell 0 |
| func_out | output | L | Parallel outputs to downstream logic |
| scan_out | output | 1 | Serial output from cell L-1 |
| scan_en | output | 1 | High during shift cycles |
| done | output | 1 | One-cycle end-of-run pulse |
| shift_tog | output | CW | Measured shift toggles |
| cap_tog | output | CW | Measured capture toggles |
| in_weight | output | CW | Weighted load-side estimate |
| out_weight | output | CW | Weighted unload-side estimate |

## Verification
The hardest state to reach is counter saturation. It needs a long run with many toggles while the counters are narrow, so the bench uses an 8-bit counter width and a run of fifteen vectors with random serial data. That drives the shift counter past its ceiling, and the next start must then clear it. A second awkward case is a start request raised in the middle of a run: the bench pulses it during a shift phase and checks that the run keeps its length and produces a single done pulse. An alternating serial pattern gives the largest load-side weight.

// File: rtl/scan_activity_chain.sv
module scan_activity_chain #(
  parameter int L  = 8,
  parameter int CW = 16,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          gate_en,
  input  logic [VW-1:0] nvec,
  input  logic [L-1:0]  func_in,
  input  logic          scan_in,
  output logic [L-1:0]  func_out,
  output logic          scan_out,
  output logic          scan_en,
  output logic          done,
  output logic [CW-1:0] shift_tog,
  output logic [CW-1:0] cap_tog,
  output logic [CW-1:0] in_weight,
  output logic [CW-1:0] out_weight
);
  localparam int CNTW = (L > 2) ? $clog2(L) : 1;
  localparam longint unsigned CMAX = (64'd1 << CW) - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_CAP} st_t;

  st_t           st;
  logic [CNTW-1:0] cnt;
  logic [VW-1:0] left;
  logic [L-1:0]  chain, frozen, shifted;
  logic          prev_si, from_cap, idle, last;
  int unsigned   shift_hd, cap_hd, in_inc, out_inc;

  function automatic logic [CW-1:0] sat(input logic [CW-1:0] a, input int unsigned b);
    longint unsigned s;
    s = longint'(a) + longint'(b);
    return (s > CMAX) ? CW'(CMAX) : CW'(s);
  endfunction

  assign shifted  = {chain[L-2:0], scan_in};
  assign idle     = (st == ST_IDLE);
  assign scan_en  = (st == ST_SHIFT);
  assign scan_out = chain[L-1];
  assign func_out = (gate_en && scan_en) ? frozen : chain;
  assign last     = (cnt == CNTW'(L-1));
  assign shift_hd = $countones(chain ^ shifted);
  assign cap_hd   = $countones(chain ^ func_in);
  assign in_inc   = (cnt != '0 && scan_in != prev_si) ? (L - int'(cnt)) : 0;

  always_comb begin
    out_inc = 0;
    for (int j = 0; j < L-1; j++)
      if (chain[j] != chain[j+1]) out_inc = out_inc + (L - 1 - j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      left       <= '0;
      chain      <= '0;
      frozen     <= '0;
      prev_si    <= 1'b0;
      from_cap   <= 1'b0;
      done       <= 1'b0;
      shift_tog  <= '0;
      cap_tog    <= '0;
      in_weight  <= '0;
      out_weight <= '0;
    end else begin
      done <= 1'b0;
      if (!scan_en) frozen <= chain;
      case (st)
        ST_IDLE: begin
          chain <= func_in;
          if (start) begin
            st         <= ST_SHIFT;
            cnt        <= '0;
            left       <= nvec;
            from_cap   <= 1'b0;
            shift_tog  <= '0;
            cap_tog    <= '0;
            in_weight  <= '0;
            out_weight <= '0;
          end
        end
        ST_SHIFT: begin
          chain     <= shifted;
          prev_si   <= scan_in;
          shift_tog <= sat(shift_tog, shift_hd);
          in_weight <= sat(in_weight, in_inc);
          if (cnt == '0 && from_cap) out_weight <= sat(out_weight, out_inc);
          cnt <= cnt + 1'b1;
          if (last) begin
            cnt <= '0;
            if (left == '0) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st   <= ST_CAP;
              left <= left - 1'b1;
            end
          end
        end
        default: begin
          chain    <= func_in;
          cap_tog  <= sat(cap_tog, cap_hd);
          from_cap <= 1'b1;
          st       <= ST_SHIFT;
        end
      endcase
    end
  end
endmodule

// File: rtl/scan_activity_chain_chk.sv
module scan_activity_chain_chk #(
  parameter int L  = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          gate_en,
  input logic          idle,
  input logic          scan_en,
  input logic          done,
  input logic [L-1:0]  func_out,
  input logic [CW-1:0] shift_tog,
  input logic [CW-1:0] cap_tog
);
  // R6
  frozen_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && scan_en && $past(gate_en && scan_en)) |-> $stable(func_out));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(scan_en));
  // R2
  start_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> scan_en);
  // R11
  shift_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle && start) |=> (shift_tog >= $past(shift_tog)));
  // R11
  cap_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle && start) |=> (cap_tog >= $past(cap_tog)));
endmodule

bind scan_activity_chain scan_activity_chain_chk #(.L(L), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .gate_en(gate_en), .idle(idle),
  .scan_en(scan_en), .done(done), .func_out(func_out),
  .shift_tog(shift_tog), .cap_tog(cap_tog)
);

// File: tb/scan_activity_chain_tb_top.sv
module scan_activity_chain_tb_top;
  localparam int L = 8, CW = 8, VW = 4;
  localparam int SMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, start = 0, gate_en = 1, scan_in = 0;
  logic [VW-1:0] nvec = '0;
  logic [L-1:0]  func_in = '0;
  logic [L-1:0]  func_out;
  logic          scan_out, scan_en, done;
  logic [CW-1:0] shift_tog, cap_tog, in_weight, out_weight;

  always #4 clk = ~clk;

  scan_activity_chain #(.L(L), .CW(CW), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_en(gate_en), .nvec(nvec),
    .func_in(func_in), .scan_in(scan_in), .func_out(func_out),
    .scan_out(scan_out), .scan_en(scan_en), .done(done),
    .shift_tog(shift_tog), .cap_tog(cap_tog),
    .in_weight(in_weight), .out_weight(out_weight));

  int total = 0, fails = 0, dones = 0, si_mode = 0;
  bit finished = 0;

  bit mq[$], frz[$];
  int mode = 0, mcnt = 0, mleft = 0, e_sh = 0, e_cap = 0, e_in = 0, e_out = 0;
  bit mdone = 0, mprev = 0, mfromcap = 0;

  function automatic int sat(int v);
    return (v > SMAX) ? SMAX : v;
  endfunction

  function automatic logic [L-1:0] q2v(bit q[$]);
    logic [L-1:0] v;
    for (int i = 0; i < L; i++) v[i] = q[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = {}; for (int i = 0; i < L; i++) mq.push_back(1'b0);
      frz = mq; mode = 0; mcnt = 0; mleft = 0; mdone = 0; mprev = 0; mfromcap = 0;
      e_sh = 0; e_cap = 0; e_in = 0; e_out = 0;
    end else begin
      bit nd; bit nq[$]; int hd;
      nd = 0;
      if (mode != 1) frz = mq;
      if (mode == 0) begin
        if (start) begin
          mode = 1; mcnt = 0; mleft = nvec; mfromcap = 0;
          e_sh = 0; e_cap = 0; e_in = 0; e_out = 0;
        end
        for (int i = 0; i < L; i++) mq[i] = func_in[i];
      end else if (mode == 1) begin
        nq = mq; void'(nq.pop_back()); nq.push_front(scan_in);
        hd = 0;
        for (int i = 0; i < L; i++) if (nq[i] != mq[i]) hd++;
        e_sh = sat(e_sh + hd);
        if (mcnt > 0 && scan_in != mprev) e_in = sat(e_in + L - mcnt);
        if (mcnt == 0 && mfromcap) begin
          int w; w = 0;
          for (int j = 0; j < L-1; j++) if (mq[j] != mq[j+1]) w += L - 1 - j;
          e_out = sat(e_out + w);
        end
        mprev = scan_in; mq = nq; mcnt++;
        if (mcnt == L) begin
          mcnt = 0;
          if (mleft == 0) begin mode = 0; nd = 1; end
          else begin mode = 2; mleft--; end
        end
      end else begin
        hd = 0;
        for (int i = 0; i < L; i++) if (mq[i] != func_in[i]) hd++;
        e_cap = sat(e_cap + hd);
        for (int i = 0; i < L; i++) mq[i] = func_in[i];
        mfromcap = 1; mode = 1;
      end
      mdone = nd;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [L-1:0] efo;
    efo = (gate_en && mode == 1) ? q2v(frz) : q2v(mq);
    chk(func_out == efo, (mode == 0) ? "R1 func_out" : "R6 func_out", func_out, efo);
    chk(scan_out == mq[L-1], "R3 scan_out", scan_out, mq[L-1]);
    chk(scan_en == (mode == 1), "R2 scan_en", scan_en, mode == 1);
    chk(done == mdone, "R5 done", done, mdone);
    chk(shift_tog == e_sh, "R7 shift_tog", shift_tog, e_sh);
    chk(cap_tog == e_cap, "R8 cap_tog", cap_tog, e_cap);
    chk(in_weight == e_in, "R9 in_weight", in_weight, e_in);
    chk(out_weight == e_out, "R10 out_weight", out_weight, e_out);
    if (done) dones++;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    start = 0;
    func_in = L'($urandom);
    case (si_mode)
      0: scan_in = $urandom_range(0, 1);
      1: scan_in = ~scan_in;
      default: scan_in = 1'b1;
    endcase
  endtask

  task automatic run(int n, bit g, int pat);
    gate_en = g; nvec = VW'(n); si_mode = pat;
    start = 1;
    tick();
    for (int i = 0; i < 400 && !done; i++) tick();
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(func_out == '0 && !scan_en && !done && shift_tog == '0, "R1 reset state", func_out, 0);
    rst_n = 1;
    for (int i = 0; i < 6; i++) tick();
    run(2, 1, 0);
    run(1, 0, 0);
    run(3, 1, 1);
    run(0, 1, 2);
    dones = 0; gate_en = 1; nvec = 2; si_mode = 0; start = 1;
    tick();
    for (int i = 0; i < 5; i++) tick();
    start = 1;
    tick();
    for (int i = 0; i < 60; i++) tick();
    chk(dones == 1, "R4 start ignored while busy", dones, 1);
    chk(!scan_en, "R4 run length", scan_en, 0);
    run(15, 0, 0);
    chk(shift_tog == SMAX, "R11 saturated", shift_tog, SMAX);
    start = 1;
    tick();
    chk(shift_tog == 0 && cap_tog == 0, "R11 cleared on start", shift_tog, 0);
    for (int i = 0; i < 60; i++) tick();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule